// File: doc/BRIEF.md
# Hashed Interleaved Address Range Decoder

This block decides whether an address belongs to one target, such as one cache bank or one memory channel, among several targets that stripe a shared address window. A target is described by an inclusive lower and upper address bound. It can also carry an interleave slice, given by a high bit position and a width, together with the value that slice must equal for this target. Each copy of the block in the system holds a different match value, so every address inside the window selects exactly one target.

Strided traffic can fall on only a few targets when the slice is compared directly. To avoid that, a second slice of the same width, placed independently, can be XOR-folded into the interleave slice before the comparison. The settings sit in registers that load on a write strobe. The hit decision is combinational from the address and those registers, so a new address is judged in the same cycle it arrives. The block also flags illegal settings, reports whether striping and hashing are active, and gives the stripe granule as a power-of-two exponent.

Top module: `hashed_range_decoder`

## Requirements
- R1: With interleaving off, `hit` is 1 exactly when `lo_bound <= addr <= hi_bound`, both bounds inclusive.
- R2: A slice width of 0 turns interleaving off. `intlv_on` is then 0, `hash_on` is 0, and the match value and both slice positions have no effect on `hit` or `cfg_error`.
- R3: With interleaving on and hashing off, `hit` is 1 exactly when the address is within bounds and `addr[slice_hi : slice_hi-slice_w+1]` equals the low `slice_w` bits of `match_val`.
- R4: `hash_on` is 1 exactly when `slice_w` is nonzero and `fold_hi` is nonzero. A `fold_hi` of 0 disables hashing.
- R5: With hashing on, `hit` is 1 exactly when the address is within bounds and `addr[slice_hi : slice_hi-slice_w+1] ^ addr[fold_hi : fold_hi-slice_w+1]` equals `match_val`.
- R6: With interleaving on, `cfg_error` is 1 when `match_val` does not fit in `slice_w` bits, that is when `match_val >= 2**slice_w`.
- R7: With hashing on, `cfg_error` is 1 when `slice_hi` equals `fold_hi`, or when the two differ by fewer than `slice_w` positions, since the slices would then overlap.
- R8: With interleaving on, `cfg_error` is 1 in each of these cases: `slice_w` exceeds the maximum width of 8; `slice_hi` is not below the address width; `slice_hi + 1 < slice_w`. With hashing on, it is also 1 when `fold_hi` is not below the address width or when `fold_hi + 1 < slice_w`.
- R9: Whenever `cfg_error` is 1, `hit` is 0.
- R10: If `lo_bound > hi_bound`, the range is empty. `hit` stays 0, and this alone does not raise `cfg_error`.
- R11: `granule_lg2` equals `slice_hi - slice_w + 1`, the low bit of the interleave slice, so each stripe spans `2**granule_lg2` bytes. It is 0 when interleaving is off or `cfg_error` is 1.
- R12: Reset loads `lo_bound=1`, `hi_bound=0` and zeros everywhere else, which gives `hit=0`, `cfg_error=0`, `intlv_on=0`, `hash_on=0` and `granule_lg2=0`. The settings change only on a clock edge with `cfg_we=1`. Changing the settings inputs without the strobe has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the settings registers |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads all settings inputs at the clock edge |
| cfg_lo | input | AW | Inclusive lower address bound |
| cfg_hi | input | AW | Inclusive upper address bound |
| cfg_slice_hi | input | HBW | High bit of the interleave slice |
| cfg_fold_hi | input | HBW | High bit of the XOR slice, 0 for no hashing |
| cfg_slice_w | input | WW | Slice width, 0 for no interleaving |
| cfg_match | input | IW_MAX | Value the (hashed) slice must equal |
| addr | input | AW | Address under test |
| hit | output | 1 | Address belongs to this target |
| cfg_error | output | 1 | Loaded settings are illegal |
| intlv_on | output | 1 | Interleaving is active |
| hash_on | output | 1 | Hashing is active |
| granule_lg2 | output | HBW | Exponent of the stripe granule |

## Verification
The settings take effect at the first rising edge that sees `cfg_we` high. Every output follows `addr` with no delay, so each result is due in the same cycle as its stimulus. The bench loads settings with the strobe, lowers the strobe and applies the address on the falling edge, and then samples all five outputs one time unit later. This keeps every sample a half period away from the next rising edge. The reset and ignored-write checks sample in the same way, once an edge has passed with the strobe low, so any change to the settings would already show up at the outputs.

// File: rtl/hrd_pkg.sv
package hrd_pkg;
  localparam int unsigned HRD_AW_DEF     = 48;
  localparam int unsigned HRD_IWMAX_DEF  = 8;
  localparam int unsigned HRD_HBW_DEF    = 6;

  typedef enum logic [1:0] {
    MODE_FLAT   = 2'd0,
    MODE_STRIPE = 2'd1,
    MODE_HASHED = 2'd2
  } hrd_mode_e;

  // low bit of a slice that ends at hi and spans w bits; may be negative
  function automatic int slice_low(input int hi, input int w);
    return hi - w + 1;
  endfunction

  // absolute distance between two bit positions
  function automatic int bit_gap(input int a, input int b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic hrd_mode_e pick_mode(input int w, input int fold_hi);
    if (w == 0)       return MODE_FLAT;
    if (fold_hi == 0) return MODE_STRIPE;
    return MODE_HASHED;
  endfunction
endpackage

// File: rtl/hrd_cfg_reg.sv
module hrd_cfg_reg #(
  parameter int unsigned AW     = 48,
  parameter int unsigned IW_MAX = 8,
  parameter int unsigned HBW    = 6,
  localparam int unsigned WW    = $clog2(IW_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     lo_d,
  input  logic [AW-1:0]     hi_d,
  input  logic [HBW-1:0]    shi_d,
  input  logic [HBW-1:0]    fhi_d,
  input  logic [WW-1:0]     w_d,
  input  logic [IW_MAX-1:0] m_d,
  output logic [AW-1:0]     lo_q,
  output logic [AW-1:0]     hi_q,
  output logic [HBW-1:0]    shi_q,
  output logic [HBW-1:0]    fhi_q,
  output logic [WW-1:0]     w_q,
  output logic [IW_MAX-1:0] m_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q  <= AW'(1);
      hi_q  <= '0;
      shi_q <= '0;
      fhi_q <= '0;
      w_q   <= '0;
      m_q   <= '0;
    end else if (we) begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      shi_q <= shi_d;
      fhi_q <= fhi_d;
      w_q   <= w_d;
      m_q   <= m_d;
    end
  end
endmodule

// File: rtl/hrd_slice.sv
module hrd_slice #(
  parameter int unsigned AW     = 48,
  parameter int unsigned IW_MAX = 8,
  parameter int unsigned HBW    = 6,
  localparam int unsigned WW    = $clog2(IW_MAX + 1)
) (
  input  logic [AW-1:0]     addr,
  input  logic [HBW-1:0]    top_bit,
  input  logic [WW-1:0]     width,
  output logic [IW_MAX-1:0] bits_out
);
  // shift right by the slice low bit, then keep width bits
  function automatic logic [IW_MAX-1:0] grab(input logic [AW-1:0] a,
                                             input int hi, input int w);
    logic [IW_MAX-1:0] msk;
    logic [AW-1:0]     sh;
    int                lo;
    lo  = hrd_pkg::slice_low(hi, w);
    for (int i = 0; i < int'(IW_MAX); i++) msk[i] = (i < w);
    if (w == 0 || lo < 0 || lo >= int'(AW)) begin
      sh = '0;
    end else begin
      sh = a >> lo;
    end
    return sh[IW_MAX-1:0] & msk;
  endfunction

  always_comb bits_out = grab(addr, int'(top_bit), int'(width));
endmodule

// File: rtl/hrd_cfg_check.sv
module hrd_cfg_check #(
  parameter int unsigned AW     = 48,
  parameter int unsigned IW_MAX = 8,
  parameter int unsigned HBW    = 6,
  localparam int unsigned WW    = $clog2(IW_MAX + 1)
) (
  input  logic [HBW-1:0]    shi,
  input  logic [HBW-1:0]    fhi,
  input  logic [WW-1:0]     w,
  input  logic [IW_MAX-1:0] m,
  output hrd_pkg::hrd_mode_e mode,
  output logic              bad,
  output logic [HBW-1:0]    gran
);
  function automatic logic judge(input int hi, input int fh, input int wd,
                                 input logic [IW_MAX-1:0] mv);
    logic e;
    e = 1'b0;
    if (wd != 0) begin
      if (wd > int'(IW_MAX)) e = 1'b1;
      else if ((mv >> wd) != '0) e = 1'b1;
      if (hi >= int'(AW)) e = 1'b1;
      if (hi + 1 < wd) e = 1'b1;
      if (fh != 0) begin
        if (fh >= int'(AW)) e = 1'b1;
        if (fh + 1 < wd) e = 1'b1;
        if (hrd_pkg::bit_gap(hi, fh) < wd) e = 1'b1;
      end
    end
    return e;
  endfunction

  always_comb begin
    mode = hrd_pkg::pick_mode(int'(w), int'(fhi));
    bad  = judge(int'(shi), int'(fhi), int'(w), m);
    if (mode == hrd_pkg::MODE_FLAT || bad)
      gran = '0;
    else
      gran = HBW'(hrd_pkg::slice_low(int'(shi), int'(w)));
  end
endmodule

// File: rtl/hashed_range_decoder.sv
module hashed_range_decoder #(
  parameter int unsigned AW       = hrd_pkg::HRD_AW_DEF,
  parameter int unsigned IW_MAX   = hrd_pkg::HRD_IWMAX_DEF,
  parameter int unsigned HBW      = hrd_pkg::HRD_HBW_DEF,
  parameter bit          HASH_EN  = 1'b1,
  localparam int unsigned WW      = $clog2(IW_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_lo,
  input  logic [AW-1:0]     cfg_hi,
  input  logic [HBW-1:0]    cfg_slice_hi,
  input  logic [HBW-1:0]    cfg_fold_hi,
  input  logic [WW-1:0]     cfg_slice_w,
  input  logic [IW_MAX-1:0] cfg_match,
  input  logic [AW-1:0]     addr,
  output logic              hit,
  output logic              cfg_error,
  output logic              intlv_on,
  output logic              hash_on,
  output logic [HBW-1:0]    granule_lg2
);
  logic [AW-1:0]     lo_q, hi_q;
  logic [HBW-1:0]    shi_q, fhi_q;
  logic [WW-1:0]     w_q;
  logic [IW_MAX-1:0] m_q;
  logic [IW_MAX-1:0] main_bits, fold_bits, key_bits;
  logic              in_window, key_match;
  hrd_pkg::hrd_mode_e mode;

  hrd_cfg_reg #(.AW(AW), .IW_MAX(IW_MAX), .HBW(HBW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .lo_d(cfg_lo), .hi_d(cfg_hi), .shi_d(cfg_slice_hi), .fhi_d(cfg_fold_hi),
    .w_d(cfg_slice_w), .m_d(cfg_match),
    .lo_q(lo_q), .hi_q(hi_q), .shi_q(shi_q), .fhi_q(fhi_q),
    .w_q(w_q), .m_q(m_q)
  );

  hrd_cfg_check #(.AW(AW), .IW_MAX(IW_MAX), .HBW(HBW)) u_check (
    .shi(shi_q), .fhi(fhi_q), .w(w_q), .m(m_q),
    .mode(mode), .bad(cfg_error), .gran(granule_lg2)
  );

  hrd_slice #(.AW(AW), .IW_MAX(IW_MAX), .HBW(HBW)) u_main (
    .addr(addr), .top_bit(shi_q), .width(w_q), .bits_out(main_bits)
  );

  generate
    if (HASH_EN) begin : g_fold
      hrd_slice #(.AW(AW), .IW_MAX(IW_MAX), .HBW(HBW)) u_fold (
        .addr(addr), .top_bit(fhi_q), .width(w_q), .bits_out(fold_bits)
      );
    end else begin : g_nofold
      assign fold_bits = '0;
    end
  endgenerate

  always_comb begin
    intlv_on  = (mode != hrd_pkg::MODE_FLAT);
    hash_on   = HASH_EN && (mode == hrd_pkg::MODE_HASHED);
    key_bits  = hash_on ? (main_bits ^ fold_bits) : main_bits;
    key_match = (key_bits == m_q);
    in_window = (addr >= lo_q) && (addr <= hi_q);
    hit       = in_window && !cfg_error && (!intlv_on || key_match);
  end
endmodule

// File: rtl/hashed_range_decoder_chk.sv
module hashed_range_decoder_chk #(
  parameter int unsigned AW  = 48,
  parameter int unsigned HBW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_we,
  input logic [AW-1:0]  addr,
  input logic [AW-1:0]  lo_q,
  input logic [AW-1:0]  hi_q,
  input logic           hit,
  input logic           cfg_error,
  input logic           intlv_on,
  input logic           hash_on,
  input logic [HBW-1:0] granule_lg2
);
  AST_ERR_BLOCKS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> !hit); // R9
  AST_HASH_NEEDS_STRIPE: assert property (@(posedge clk) disable iff (!rst_n)
    hash_on |-> intlv_on); // R4
  AST_HIT_INSIDE_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (addr >= lo_q && addr <= hi_q)); // R1
  AST_EMPTY_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_q > hi_q) |-> !hit); // R10
  AST_FLAT_NO_GRANULE: assert property (@(posedge clk) disable iff (!rst_n)
    (!intlv_on || cfg_error) |-> (granule_lg2 == '0)); // R11
  AST_BOUNDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(lo_q) && $stable(hi_q))); // R12
endmodule

bind hashed_range_decoder hashed_range_decoder_chk #(.AW(AW), .HBW(HBW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .addr(addr),
  .lo_q(lo_q), .hi_q(hi_q), .hit(hit), .cfg_error(cfg_error),
  .intlv_on(intlv_on), .hash_on(hash_on), .granule_lg2(granule_lg2)
);

// File: tb/tb_hashed_range_decoder.sv
module tb_hashed_range_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 48;
  localparam int NV = 20;

  typedef struct packed {
    logic [47:0] lo;
    logic [47:0] hi;
    logic [5:0]  shi;
    logic [5:0]  fhi;
    logic [3:0]  w;
    logic [7:0]  m;
    logic [47:0] a;
    logic        e_hit;
    logic        e_err;
    logic        e_int;
    logic        e_hash;
    logic [5:0]  e_gran;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{48'h1000, 48'h1FFF, 6'd0,  6'd0,  4'd0, 8'd0, 48'h1000, 1'b1,1'b0,1'b0,1'b0,6'd0, 8'd1},  // R1 low edge
    '{48'h1000, 48'h1FFF, 6'd0,  6'd0,  4'd0, 8'd0, 48'h1FFF, 1'b1,1'b0,1'b0,1'b0,6'd0, 8'd1},  // R1 high edge
    '{48'h1000, 48'h1FFF, 6'd0,  6'd0,  4'd0, 8'd0, 48'h0FFF, 1'b0,1'b0,1'b0,1'b0,6'd0, 8'd1},  // R1 below
    '{48'h1000, 48'h1FFF, 6'd0,  6'd0,  4'd0, 8'd0, 48'h2000, 1'b0,1'b0,1'b0,1'b0,6'd0, 8'd1},  // R1 above
    '{48'h1000, 48'h1FFF, 6'd3,  6'd10, 4'd0, 8'd5, 48'h1800, 1'b1,1'b0,1'b0,1'b0,6'd0, 8'd2},  // R2 ignored fields
    '{48'h0,    48'hFFFF, 6'd7,  6'd0,  4'd2, 8'd2, 48'h0080, 1'b1,1'b0,1'b1,1'b0,6'd6, 8'd3},  // R3 match
    '{48'h0,    48'hFFFF, 6'd7,  6'd0,  4'd2, 8'd2, 48'h00C0, 1'b0,1'b0,1'b1,1'b0,6'd6, 8'd3},  // R3 miss
    '{48'h0,    48'hFFFF, 6'd7,  6'd0,  4'd2, 8'd2, 48'h10080,1'b0,1'b0,1'b1,1'b0,6'd6, 8'd3},  // R3 out of bounds
    '{48'h0,    48'hFFFF, 6'd7,  6'd13, 4'd2, 8'd1, 48'h3080, 1'b1,1'b0,1'b1,1'b1,6'd6, 8'd5},  // R5 2^3=1
    '{48'h0,    48'hFFFF, 6'd7,  6'd13, 4'd2, 8'd1, 48'h0080, 1'b0,1'b0,1'b1,1'b1,6'd6, 8'd5},  // R5 2^0=2
    '{48'h0,    48'hFFFF, 6'd7,  6'd13, 4'd2, 8'd1, 48'h20C0, 1'b1,1'b0,1'b1,1'b1,6'd6, 8'd5},  // R5 3^2=1
    '{48'h0,    48'hFFFF, 6'd7,  6'd0,  4'd2, 8'd4, 48'h0080, 1'b0,1'b1,1'b1,1'b0,6'd0, 8'd6},  // R6 R9
    '{48'h0,    48'hFFFF, 6'd7,  6'd8,  4'd2, 8'd1, 48'h0080, 1'b0,1'b1,1'b1,1'b1,6'd0, 8'd7},  // R7 gap 1
    '{48'h0,    48'hFFFF, 6'd7,  6'd7,  4'd2, 8'd1, 48'h0080, 1'b0,1'b1,1'b1,1'b1,6'd0, 8'd7},  // R7 equal
    '{48'h0,    48'hFFFF, 6'd7,  6'd9,  4'd2, 8'd2, 48'h0080, 1'b1,1'b0,1'b1,1'b1,6'd6, 8'd7},  // R7 gap 2 legal
    '{48'h0,    48'hFFFF, 6'd13, 6'd7,  4'd2, 8'd1, 48'h3080, 1'b1,1'b0,1'b1,1'b1,6'd12,8'd5},  // R5 fold below
    '{48'h0,    48'hFFFF, 6'd50, 6'd0,  4'd2, 8'd0, 48'h0080, 1'b0,1'b1,1'b1,1'b0,6'd0, 8'd8},  // R8 hi too big
    '{48'h0,    48'hFFFF, 6'd0,  6'd0,  4'd2, 8'd0, 48'h0080, 1'b0,1'b1,1'b1,1'b0,6'd0, 8'd8},  // R8 below bit 0
    '{48'h0,    48'hFFFF, 6'd10, 6'd0,  4'd9, 8'd0, 48'h0080, 1'b0,1'b1,1'b1,1'b0,6'd0, 8'd8},  // R8 width 9
    '{48'h2000, 48'h1000, 6'd0,  6'd0,  4'd0, 8'd0, 48'h1800, 1'b0,1'b0,1'b0,1'b0,6'd0, 8'd10}  // R10 empty
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [47:0] cfg_lo = '0, cfg_hi = '0, addr = '0;
  logic [5:0]  cfg_slice_hi = '0, cfg_fold_hi = '0;
  logic [3:0]  cfg_slice_w = '0;
  logic [7:0]  cfg_match = '0;
  logic        hit, cfg_error, intlv_on, hash_on;
  logic [5:0]  granule_lg2;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hashed_range_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_slice_hi(cfg_slice_hi),
    .cfg_fold_hi(cfg_fold_hi), .cfg_slice_w(cfg_slice_w), .cfg_match(cfg_match),
    .addr(addr), .hit(hit), .cfg_error(cfg_error), .intlv_on(intlv_on),
    .hash_on(hash_on), .granule_lg2(granule_lg2)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic load(input vec_t v);
    @(negedge clk);
    cfg_lo = v.lo; cfg_hi = v.hi; cfg_slice_hi = v.shi; cfg_fold_hi = v.fhi;
    cfg_slice_w = v.w; cfg_match = v.m; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    addr = v.a;
    #1;
  endtask

  task automatic check_all(input string tag, input logic h, input logic e,
                           input logic i, input logic s, input logic [5:0] g);
    chk({tag, " hit"},   64'(hit),         64'(h));
    chk({tag, " error"}, 64'(cfg_error),   64'(e));
    chk({tag, " intlv"}, 64'(intlv_on),    64'(i));
    chk({tag, " hash"},  64'(hash_on),     64'(s));
    chk({tag, " gran"},  64'(granule_lg2), 64'(g));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    addr = 48'h0;
    @(negedge clk); #1;
    check_all("R12 reset addr0", 1'b0, 1'b0, 1'b0, 1'b0, 6'd0);
    addr = 48'h1; #1;
    chk("R12 reset addr1 hit", 64'(hit), 64'd0);

    for (int k = 0; k < NV; k++) begin
      load(VECS[k]);
      check_all($sformatf("R%0d vec%0d", VECS[k].req, k), VECS[k].e_hit,
                VECS[k].e_err, VECS[k].e_int, VECS[k].e_hash, VECS[k].e_gran);
    end

    // R12: settings inputs change without strobe -> no effect
    load(VECS[5]);
    @(negedge clk);
    cfg_match = 8'd3; cfg_slice_w = 4'd0; cfg_lo = 48'h9000; cfg_hi = 48'h9FFF;
    @(negedge clk); @(negedge clk); #1;
    check_all("R12 no strobe", 1'b1, 1'b0, 1'b1, 1'b0, 6'd6);

    // R3: sweep all four slice values, only value 2 hits
    for (int s = 0; s < 4; s++) begin
      addr = 48'(s) << 6; #1;
      chk($sformatf("R3 sweep %0d", s), 64'(hit), (s == 2) ? 64'd1 : 64'd0);
    end

    // R12: reset restores defaults mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; addr = 48'h80; #1;
    check_all("R12 re-reset", 1'b0, 1'b0, 1'b0, 1'b0, 6'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule